// File: doc/BRIEF.md
# Packed Widening Multiply and OR Execution Unit

This unit is one pipelined execution slot of a 256-bit vector integer datapath. Each accepted operation carries two source vectors, the old contents of the destination register, an operation select and a width mode. The multiply operation takes the unsigned 32-bit elements at even element positions and produces a full 64-bit unsigned product for each. The OR operation combines the two operands bit by bit. Both operations go through the same result-merge stage.

The width mode sets which operands are used and what ends up in the upper 128 result bits. In the preserving 128-bit mode the first operand is the old destination value, and the upper half of that old value passes through unchanged. In the zeroing 128-bit mode the upper half is cleared. In the full 256-bit mode all lanes are computed. Operations enter through a valid/ready handshake and leave three pipeline steps later with their tag. An output stall freezes every stage.

Top module: `simd_widen_mul`

## Requirements
- R1: With `in_op`=0 (multiply), result bits [64k+63:64k] equal the unsigned 64-bit product of 32-bit element 2k of the first operand and 32-bit element 2k of `in_src2`. Element j occupies bits [32j+31:32j].
- R2: Odd-numbered 32-bit elements of both operands never affect a multiply result.
- R3: `in_mode`=2 (full 256-bit) computes all four 64-bit lanes. `in_mode`=3 behaves exactly like 2.
- R4: `in_mode`=1 (zeroing 128-bit) computes bits [127:0] and drives bits [255:128] to zero.
- R5: `in_mode`=0 (preserving 128-bit) uses `in_old_dst` as the first operand and ignores `in_src1`. Bits [127:0] are computed and bits [255:128] equal `in_old_dst[255:128]`.
- R6: With `in_op`=1 (OR), each computed result bit is the OR of the matching first-operand and `in_src2` bits. The upper half follows the same mode rule as R3 to R5.
- R7: With `out_ready` held high, an operation accepted at one rising edge appears on `out_valid` after the third rising edge.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_tag` and `out_valid` hold and `in_ready` is 0. `in_ready` is 1 whenever the output register is empty or being drained.
- R9: Results leave in acceptance order, and each carries the `in_tag` given with its operation.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept this cycle |
| in_op | input | 1 | 0 multiply, 1 OR |
| in_mode | input | 2 | 0 preserving 128, 1 zeroing 128, 2/3 full 256 |
| in_tag | input | 4 | Operation identifier |
| in_src1 | input | 256 | First operand (not used in mode 0) |
| in_src2 | input | 256 | Second operand |
| in_old_dst | input | 256 | Old destination contents |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_tag | output | 4 | Tag of the result |
| out_data | output | 256 | Result vector |

## Verification
The bench uses all-ones operands in every mode to reach the largest product, 0xFFFFFFFE00000001. A split multiplier that drops a carry between its partial sums gives a wrong value there. It loads the odd elements and `in_src1` with values that differ from the ones used, so a design that reads the wrong element or the wrong first operand in preserving mode gives the wrong answer. Random stalls on `out_ready`, together with a scoreboard ordered by tag, catch a stage that advances while stalled: results get lost, duplicated or reordered. The bench also times a lone operation to catch an extra or missing pipeline register.

// File: rtl/simd_widen_mul.sv
module simd_widen_mul #(
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter int TAG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_op,
  input  logic [1:0]            in_mode,
  input  logic [TAG_W-1:0]      in_tag,
  input  logic [2*EW*LANES-1:0] in_src1,
  input  logic [2*EW*LANES-1:0] in_src2,
  input  logic [2*EW*LANES-1:0] in_old_dst,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [TAG_W-1:0]      out_tag,
  output logic [2*EW*LANES-1:0] out_data
);
  localparam int PW   = 2 * EW;
  localparam int DW   = PW * LANES;
  localparam int HALF = DW / 2;
  localparam int LOWN = LANES / 2;
  localparam int HW   = EW / 2;
  localparam logic [1:0] M_KEEP = 2'd0;
  localparam logic [1:0] M_ZERO = 2'd1;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic [DW-1:0] opa;
  assign opa = (in_mode == M_KEEP) ? in_old_dst : in_src1;

  // stage 1
  logic              v1, op1;
  logic [1:0]        mode1;
  logic [TAG_W-1:0]  tag1;
  logic [LANES-1:0][EW-1:0] a1, b1;
  logic [DW-1:0]     or1;
  logic [HALF-1:0]   keep1;
  // stage 2
  logic              v2, op2;
  logic [1:0]        mode2;
  logic [TAG_W-1:0]  tag2;
  logic [LANES-1:0][EW-1:0] ll2, lh2, hl2, hh2;
  logic [DW-1:0]     or2;
  logic [HALF-1:0]   keep2;
  // stage 3 state
  logic              op3;
  logic [1:0]        mode3;
  logic [DW-1:0]     res_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; out_valid <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid; v2 <= v1; out_valid <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      op1   <= in_op;  mode1 <= in_mode; tag1 <= in_tag;
      or1   <= opa | in_src2;
      keep1 <= in_old_dst[DW-1:HALF];
      op2   <= op1;    mode2 <= mode1;   tag2 <= tag1;
      or2   <= or1;    keep2 <= keep1;
      op3   <= op2;    mode3 <= mode2;   out_tag <= tag2;
      out_data <= res_d;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PW-1:0] prod;
    logic [PW-1:0] lane_res;

    always_ff @(posedge clk) begin
      if (adv) begin
        a1[k]  <= opa[k*PW +: EW];
        b1[k]  <= in_src2[k*PW +: EW];
        ll2[k] <= a1[k][HW-1:0]  * b1[k][HW-1:0];
        lh2[k] <= a1[k][HW-1:0]  * b1[k][EW-1:HW];
        hl2[k] <= a1[k][EW-1:HW] * b1[k][HW-1:0];
        hh2[k] <= a1[k][EW-1:HW] * b1[k][EW-1:HW];
      end
    end

    assign prod = {hh2[k], ll2[k]}
                + {{HW{1'b0}}, lh2[k], {HW{1'b0}}}
                + {{HW{1'b0}}, hl2[k], {HW{1'b0}}};
    assign lane_res = op2 ? or2[k*PW +: PW] : prod;

    if (k < LOWN) begin : g_low
      assign res_d[k*PW +: PW] = lane_res;
    end else begin : g_high
      always_comb begin
        case (mode2)
          M_KEEP:  res_d[k*PW +: PW] = keep2[(k-LOWN)*PW +: PW];
          M_ZERO:  res_d[k*PW +: PW] = '0;
          default: res_d[k*PW +: PW] = lane_res;
        endcase
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag));

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  p_zero_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode3 == M_ZERO |-> out_data[DW-1:HALF] == '0);

  p_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(v2));

  p_or_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op3 && mode3 != M_KEEP && mode3 != M_ZERO |->
      (out_data & $past(or2, 1)) == out_data || !$past(adv));
endmodule

// File: tb/test_simd_widen_mul.sv
module test_simd_widen_mul;
  localparam int DW = 256;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_op = 1'b0, out_valid, out_ready = 1'b0;
  logic [1:0] in_mode = 2'd0;
  logic [3:0] in_tag = '0, out_tag;
  logic [DW-1:0] in_src1 = '0, in_src2 = '0, in_old_dst = '0, out_data;

  always #2 clk = ~clk;

  simd_widen_mul i_simd_widen_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_mode(in_mode), .in_tag(in_tag), .in_src1(in_src1),
    .in_src2(in_src2), .in_old_dst(in_old_dst), .out_valid(out_valid),
    .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data));

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  logic [3:0]    tag_q[$];
  string         req_q[$];

  function automatic logic [DW-1:0] model(input logic op, input logic [1:0] md,
      input logic [DW-1:0] s1, input logic [DW-1:0] s2, input logic [DW-1:0] od);
    logic [DW-1:0] r, a;
    a = (md == 2'd0) ? od : s1;
    for (int k = 0; k < 4; k++) begin
      if (op) r[k*64 +: 64] = a[k*64 +: 64] | s2[k*64 +: 64];
      else    r[k*64 +: 64] = 64'(a[k*64 +: 32]) * 64'(s2[k*64 +: 32]);
    end
    if (md == 2'd0) r[255:128] = od[255:128];
    else if (md == 2'd1) r[255:128] = '0;
    return r;
  endfunction

  function automatic string rname(input logic op, input logic [1:0] md);
    string s;
    s = op ? "R6" : "R1";
    case (md)
      2'd0: s = {s, "/R5"};
      2'd1: s = {s, "/R4"};
      default: s = {s, "/R3"};
    endcase
    return s;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd256();
    logic [DW-1:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // one negedge step: drain check, then drive/offer
  bit stalled = 0;
  logic [DW-1:0] st_data;
  logic [3:0] st_tag;
  task automatic step(input bit offer, input logic op, input logic [1:0] md,
      input logic [DW-1:0] s1, input logic [DW-1:0] s2, input logic [DW-1:0] od,
      input string req, input bit rdy);
    @(negedge clk);
    if (stalled) begin
      check("R8 hold data", out_data, st_data);
      check("R8 hold tag", {252'd0, out_tag}, {252'd0, st_tag});
      check("R8 hold valid", {255'd0, out_valid}, 256'd1);
    end
    out_ready = rdy;
    if (out_valid && rdy) begin
      if (exp_q.size() == 0) check("R9 unexpected result", 256'd1, 256'd0);
      else begin
        check(req_q[0], out_data, exp_q[0]);
        check("R9 tag order", {252'd0, out_tag}, {252'd0, tag_q[0]});
        void'(exp_q.pop_front()); void'(tag_q.pop_front()); void'(req_q.pop_front());
      end
    end
    stalled = out_valid && !rdy;
    st_data = out_data; st_tag = out_tag;
    in_valid = offer; in_op = op; in_mode = md;
    in_src1 = s1; in_src2 = s2; in_old_dst = od;
    #0.5;
    if (out_valid && !rdy) check("R8 ready low", {255'd0, in_ready}, 256'd0);
    if (!out_valid) check("R8 ready high", {255'd0, in_ready}, 256'd1);
    if (offer && in_ready) begin
      exp_q.push_back(model(op, md, s1, s2, od));
      tag_q.push_back(in_tag);
      req_q.push_back(req);
    end
  endtask

  task automatic issue(input logic op, input logic [1:0] md, input logic [DW-1:0] s1,
      input logic [DW-1:0] s2, input logic [DW-1:0] od, input string req, input bit rdy_rand);
    bit acc = 0;
    while (!acc) begin
      bit r;
      r = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      step(1'b1, op, md, s1, s2, od, req, r);
      acc = in_ready;
    end
    @(posedge clk); #0.1;
    in_tag = in_tag + 4'd1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 2'd0, '0, '0, '0, "idle", 1'b1);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R10 out_valid reset", {255'd0, out_valid}, 256'd0);
    check("R10 in_ready reset", {255'd0, in_ready}, 256'd1);
    rst_n = 1'b1;

    // R7 latency with a lone operation
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_op = 1'b0; in_mode = 2'd2;
    in_src1 = {8{32'd3}}; in_src2 = {8{32'd5}}; in_old_dst = '0;
    @(negedge clk); in_valid = 1'b0; in_tag = in_tag + 4'd1;
    check("R7 not yet (1)", {255'd0, out_valid}, 256'd0);
    @(negedge clk);
    check("R7 not yet (2)", {255'd0, out_valid}, 256'd0);
    @(negedge clk);
    check("R7 valid after third edge", {255'd0, out_valid}, 256'd1);
    check("R7 data", out_data, {4{64'd15}});
    drain();

    // all-ones corners, every mode and op
    for (int op = 0; op < 2; op++)
      for (int md = 0; md < 4; md++)
        issue(op[0], md[1:0], '1, '1, '1, rname(op[0], md[1:0]), 1'b0);
    drain();

    // R5: src1 must be ignored in preserving mode; old_dst upper kept
    issue(1'b0, 2'd0, rnd256(), {8{32'hFFFF_FFFF}}, rnd256(), "R5 src1 ignored", 1'b0);
    issue(1'b1, 2'd0, '1, '0, {128'h1234, 128'h0}, "R5 or keep", 1'b0);
    issue(1'b0, 2'd3, {8{32'h8000_0001}}, {8{32'hFFFF_FFFF}}, '1, "R3 mode3", 1'b0);
    // R2: odd elements garbage, same expected as zero odd elements
    begin
      logic [DW-1:0] a, b, ao, bo;
      a = rnd256(); b = rnd256();
      ao = a; bo = b;
      for (int k = 0; k < 4; k++) begin
        ao[k*64+32 +: 32] = 32'hDEAD_BEEF; bo[k*64+32 +: 32] = 32'hFFFF_FFFF;
        a[k*64+32 +: 32] = 32'h0;          b[k*64+32 +: 32] = 32'h0;
      end
      issue(1'b0, 2'd2, ao, bo, '0, "R2 odd ignored", 1'b0);
      check("R2 model independent of odd", model(1'b0, 2'd2, ao, bo, '0),
            model(1'b0, 2'd2, a, b, '0));
    end
    drain();

    // random mix with stalls
    for (int n = 0; n < 1500; n++) begin
      logic op;
      logic [1:0] md;
      op = $urandom % 2; md = $urandom % 4;
      issue(op, md, rnd256(), rnd256(), rnd256(), rname(op, md), 1'b1);
      if ($urandom % 8 == 0) step(1'b0, 1'b0, 2'd0, '0, '0, '0, "bubble", ($urandom % 2) == 1);
    end
    drain();
    check("R9 all results returned", {224'd0, 32'(exp_q.size())}, 256'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule